// File: doc/BRIEF.md
# Multi-Mode Trigger Recognizer

This block watches a stream of 16-channel samples, plus one external trigger line, and decides when a programmed trigger condition has been met. Each sample arrives with `smp_valid` high. Only valid samples advance the recognizer's time base, so every count and window below is measured in valid samples, not in clock cycles. The block never applies back-pressure: a sample offered with `smp_valid` high is always consumed in that cycle, so the stream interface needs no ready signal.

A pattern holds one three-bit term for each of the 17 inputs. The 16 channels take term slots 0 to 15 and the external line takes slot 16. A term can ask for a level or an edge. A mode selector then turns the pattern, or the channel activity around a reference clock marker, into a trigger event. Detection runs all the time. A trigger is reported only while the block is armed. Reporting one trigger disarms the block, and only a pulse on `arm` arms it again. The configuration inputs are expected to stay stable while the block is armed.

Top module: `trg_recognizer`

## Requirements
- R1: Term code 1 requires the input to be low, code 2 requires it high, and codes 0, 5, 6 and 7 are don't-care. The term for input i sits at `cfg_term[3i+2:3i]`, and the external line is input 16. In mode 0 (occur), any valid sample on which every term holds is a hit.
- R2: Term code 3 (rising edge) and code 4 (falling edge) compare the current sample with the previous valid sample. Edge terms never hold on the first valid sample after reset.
- R3: Mode 1 (longer): a hit occurs on the valid sample where the count of consecutive matching samples first exceeds `cfg_time`.
- R4: Mode 2 (shorter): a hit occurs on the first non-matching sample after a run of 1 to `cfg_time` matching samples. A longer run gives no hit.
- R5: Mode 3 (start): a hit occurs on a matching sample whose previous valid sample did not match, or which is the first sample after reset.
- R6: Mode 4 (end): a hit occurs on a non-matching sample whose previous valid sample matched.
- R7: Mode 5 (setup violation): a hit occurs on a sample with `ref_edge` high if any of the 16 channels changed value on that sample or on one of the `cfg_setup`-1 valid samples before it.
- R8: Mode 6 (hold violation): a hit occurs on a sample with `ref_edge` low where any channel changes value, provided that sample is one of the `cfg_hold` valid samples after the latest reference sample.
- R9: A hit while armed raises `trig_pulse` for exactly one cycle, in the cycle after the sample, and clears `armed`. No pulse occurs while disarmed. A pulse on `arm` sets `armed` from the next cycle.
- R10: A cycle with `smp_valid` low is ignored. It produces no trigger and does not change the previous-sample, run or window state.
- R11: After reset, `trig_pulse` and `armed` are both low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| arm | input | 1 | One-cycle pulse that arms the recognizer |
| smp_valid | input | 1 | The sample on this cycle is valid |
| smp_data | input | 16 | Channel sample |
| ext_in | input | 1 | External trigger line, term slot 16 |
| ref_edge | input | 1 | Marks the sample taken at the reference clock edge |
| cfg_mode | input | 3 | Recognition mode, codes 0 to 6 |
| cfg_term | input | 51 | Seventeen 3-bit terms |
| cfg_time | input | 8 | Run-length threshold for modes 1 and 2 |
| cfg_setup | input | 4 | Setup window in samples |
| cfg_hold | input | 4 | Hold window in samples |
| trig_pulse | output | 1 | One-cycle trigger indication |
| armed | output | 1 | Recognizer is armed |

## Verification
The hardest cases to reach from the ports are the ones that depend on history:
- a run that has just passed the threshold;
- a change that falls exactly at the edge of a setup or hold window;
- an edge term that would be corrupted if an invalid cycle were not ignored.

The stimulus resets the block before each mode so that the history is known. It then walks sample sequences that land one sample inside and one sample outside each window and threshold. To expose an invalid cycle that was wrongly consumed, it inserts a non-valid cycle carrying conflicting data just before an edge that must still be seen.

// File: rtl/trg_pkg.sv
package trg_pkg;
  typedef enum logic [2:0] {
    MODE_OCCUR   = 3'd0,
    MODE_LONGER  = 3'd1,
    MODE_SHORTER = 3'd2,
    MODE_START   = 3'd3,
    MODE_END     = 3'd4,
    MODE_SETUP   = 3'd5,
    MODE_HOLD    = 3'd6
  } trg_mode_e;

  localparam logic [2:0] TERM_LOW  = 3'd1;
  localparam logic [2:0] TERM_HIGH = 3'd2;
  localparam logic [2:0] TERM_RISE = 3'd3;
  localparam logic [2:0] TERM_FALL = 3'd4;
endpackage

// File: rtl/trg_term_match.sv
module trg_term_match #(
  parameter int NT = 17
) (
  input  logic [NT-1:0]   cur,
  input  logic [NT-1:0]   prev,
  input  logic            have_prev,
  input  logic [3*NT-1:0] terms,
  output logic            match
);
  import trg_pkg::*;
  logic [NT-1:0] ok;

  for (genvar i = 0; i < NT; i++) begin : g_term
    always_comb begin
      unique case (terms[3*i +: 3])
        TERM_LOW:  ok[i] = ~cur[i];
        TERM_HIGH: ok[i] = cur[i];
        TERM_RISE: ok[i] = have_prev & ~prev[i] & cur[i];
        TERM_FALL: ok[i] = have_prev & prev[i] & ~cur[i];
        default:   ok[i] = 1'b1;
      endcase
    end
  end

  assign match = &ok;
endmodule

// File: rtl/trg_run_track.sv
module trg_run_track #(
  parameter int TW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          adv,
  input  logic          match,
  input  logic [TW-1:0] cfg_time,
  output logic          start_hit,
  output logic          end_hit,
  output logic          long_hit,
  output logic          short_hit
);
  localparam int CW = TW + 1;
  localparam logic [CW-1:0] CMAX = '1;

  logic [CW-1:0] run_q;
  logic          in_run;

  assign in_run    = (run_q != '0);
  assign start_hit = match & ~in_run;
  assign end_hit   = ~match & in_run;
  assign long_hit  = match & (run_q == {1'b0, cfg_time});
  assign short_hit = ~match & in_run & (run_q <= {1'b0, cfg_time});

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      run_q <= '0;
    end else if (adv) begin
      if (!match)            run_q <= '0;
      else if (run_q != CMAX) run_q <= run_q + 1'b1;
    end
  end
endmodule

// File: rtl/trg_window.sv
module trg_window #(
  parameter int WW = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          adv,
  input  logic          chg,
  input  logic          ref_edge,
  input  logic [WW-1:0] cfg_setup,
  input  logic [WW-1:0] cfg_hold,
  output logic          setup_hit,
  output logic          hold_hit
);
  localparam int SW = WW + 1;
  localparam logic [SW-1:0] SMAX = '1;

  logic [SW-1:0] since_q, since_now;
  logic [WW-1:0] hold_q;

  always_comb begin
    if (chg)                 since_now = '0;
    else if (since_q != SMAX) since_now = since_q + 1'b1;
    else                     since_now = since_q;
  end

  assign setup_hit = ref_edge & (since_now < {1'b0, cfg_setup});
  assign hold_hit  = ~ref_edge & chg & (hold_q != '0);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      since_q <= SMAX;
      hold_q  <= '0;
    end else if (adv) begin
      since_q <= since_now;
      if (ref_edge)          hold_q <= cfg_hold;
      else if (hold_q != '0) hold_q <= hold_q - 1'b1;
    end
  end
endmodule

// File: rtl/trg_recognizer.sv
module trg_recognizer #(
  parameter int CH = 16,
  parameter int TW = 8,
  parameter int WW = 4,
  localparam int NT = CH + 1
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            arm,
  input  logic            smp_valid,
  input  logic [CH-1:0]   smp_data,
  input  logic            ext_in,
  input  logic            ref_edge,
  input  logic [2:0]      cfg_mode,
  input  logic [3*NT-1:0] cfg_term,
  input  logic [TW-1:0]   cfg_time,
  input  logic [WW-1:0]   cfg_setup,
  input  logic [WW-1:0]   cfg_hold,
  output logic            trig_pulse,
  output logic            armed
);
  import trg_pkg::*;

  logic [NT-1:0] cur, prev_q;
  logic have_prev_q, match, chg, hit, fire;
  logic start_hit, end_hit, long_hit, short_hit, setup_hit, hold_hit;

  assign cur = {ext_in, smp_data};
  assign chg = have_prev_q & (smp_data != prev_q[CH-1:0]);

  trg_term_match #(.NT(NT)) u_match (
    .cur(cur), .prev(prev_q), .have_prev(have_prev_q),
    .terms(cfg_term), .match(match)
  );

  trg_run_track #(.TW(TW)) u_run (
    .clk(clk), .rst_n(rst_n), .adv(smp_valid), .match(match),
    .cfg_time(cfg_time), .start_hit(start_hit), .end_hit(end_hit),
    .long_hit(long_hit), .short_hit(short_hit)
  );

  trg_window #(.WW(WW)) u_win (
    .clk(clk), .rst_n(rst_n), .adv(smp_valid), .chg(chg),
    .ref_edge(ref_edge), .cfg_setup(cfg_setup), .cfg_hold(cfg_hold),
    .setup_hit(setup_hit), .hold_hit(hold_hit)
  );

  always_comb begin
    unique case (trg_mode_e'(cfg_mode))
      MODE_OCCUR:   hit = match;
      MODE_LONGER:  hit = long_hit;
      MODE_SHORTER: hit = short_hit;
      MODE_START:   hit = start_hit;
      MODE_END:     hit = end_hit;
      MODE_SETUP:   hit = setup_hit;
      MODE_HOLD:    hit = hold_hit;
      default:      hit = 1'b0;
    endcase
  end

  assign fire = smp_valid & armed & hit;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      prev_q      <= '0;
      have_prev_q <= 1'b0;
      trig_pulse  <= 1'b0;
      armed       <= 1'b0;
    end else begin
      if (smp_valid) begin
        prev_q      <= cur;
        have_prev_q <= 1'b1;
      end
      trig_pulse <= fire;
      armed      <= (armed & ~fire) | arm;
    end
  end
endmodule

// File: rtl/trg_recognizer_chk.sv
module trg_recognizer_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       arm,
  input logic       smp_valid,
  input logic       ref_edge,
  input logic [2:0] cfg_mode,
  input logic       trig_pulse,
  input logic       armed
);
  p_single_pulse_r9: assert property (@(posedge clk) disable iff (!rst_n)
    trig_pulse |=> !trig_pulse);

  p_disarm_after_fire_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (trig_pulse && !$past(arm)) |-> !armed);

  p_arm_source_r9: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(armed) |-> $past(arm));

  p_needs_sample_r10: assert property (@(posedge clk) disable iff (!rst_n)
    trig_pulse |-> ($past(smp_valid) && $past(armed)));

  p_setup_on_ref_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (trig_pulse && $past(cfg_mode) == 3'd5) |-> $past(ref_edge));

  p_hold_off_ref_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (trig_pulse && $past(cfg_mode) == 3'd6) |-> !$past(ref_edge));
endmodule

bind trg_recognizer trg_recognizer_chk u_chk (
  .clk(clk), .rst_n(rst_n), .arm(arm), .smp_valid(smp_valid),
  .ref_edge(ref_edge), .cfg_mode(cfg_mode), .trig_pulse(trig_pulse),
  .armed(armed)
);

// File: tb/trg_recognizer_bench.sv
module trg_recognizer_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        arm = 1'b0;
  logic        smp_valid = 1'b0;
  logic [15:0] smp_data = '0;
  logic        ext_in = 1'b0;
  logic        ref_edge = 1'b0;
  logic [2:0]  cfg_mode = '0;
  logic [50:0] cfg_term = '0;
  logic [7:0]  cfg_time = '0;
  logic [3:0]  cfg_setup = '0;
  logic [3:0]  cfg_hold = '0;
  logic        trig_pulse, armed;

  int errors = 0;
  int checks = 0;
  int cycles = 0;
  logic  exp_q[$];
  string tag_q[$];

  always #2 clk = ~clk;

  trg_recognizer u_trg_recognizer (
    .clk(clk), .rst_n(rst_n), .arm(arm), .smp_valid(smp_valid),
    .smp_data(smp_data), .ext_in(ext_in), .ref_edge(ref_edge),
    .cfg_mode(cfg_mode), .cfg_term(cfg_term), .cfg_time(cfg_time),
    .cfg_setup(cfg_setup), .cfg_hold(cfg_hold),
    .trig_pulse(trig_pulse), .armed(armed)
  );

  // monitor: compares the pulse one edge after each driven cycle
  always @(posedge clk) begin
    #1;
    if (exp_q.size() > 0) begin
      logic  e;
      string t;
      e = exp_q.pop_front();
      t = tag_q.pop_front();
      checks++;
      if (trig_pulse !== e) begin
        errors++;
        $display("FAIL %s trig_pulse actual=%b expected=%b", t, trig_pulse, e);
      end
    end
  end

  task automatic step(input logic v, input logic [15:0] d, input logic e,
                      input logic r, input logic exp, input string tag);
    @(negedge clk);
    arm = 1'b0; smp_valid = v; smp_data = d; ext_in = e; ref_edge = r;
    exp_q.push_back(exp); tag_q.push_back(tag);
  endtask

  task automatic pulse_arm();
    @(negedge clk);
    arm = 1'b1; smp_valid = 1'b0; ref_edge = 1'b0;
    exp_q.push_back(1'b0); tag_q.push_back("R9");
  endtask

  task automatic check_armed(input logic exp, input string tag);
    @(negedge clk);
    checks++;
    if (armed !== exp) begin
      errors++;
      $display("FAIL %s armed actual=%b expected=%b", tag, armed, exp);
    end
    arm = 1'b0; smp_valid = 1'b0; ref_edge = 1'b0;
    exp_q.push_back(1'b0); tag_q.push_back(tag);
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0; arm = 1'b0; smp_valid = 1'b0; ref_edge = 1'b0;
    cfg_term = '0;
    @(negedge clk);
    @(negedge clk);
    rst_n = 1'b1;
  endtask

  initial begin
    do_reset();
    @(negedge clk);
    checks += 2;
    if (trig_pulse !== 1'b0 || armed !== 1'b0) begin
      errors++;
      $display("FAIL R11 trig=%b armed=%b expected 0 0", trig_pulse, armed);
    end

    // R1 occurrence with level terms and the external line
    cfg_mode = 3'd0;
    cfg_term[0 +: 3] = 3'd2; cfg_term[3 +: 3] = 3'd1; cfg_term[48 +: 3] = 3'd2;
    pulse_arm();
    step(1, 16'h0001, 0, 0, 0, "R1");
    step(1, 16'h0003, 1, 0, 0, "R1");
    step(1, 16'h0001, 1, 0, 1, "R1");
    step(1, 16'h0001, 1, 0, 0, "R9");
    check_armed(1'b0, "R9");
    pulse_arm();
    step(0, 16'h0001, 1, 0, 0, "R10");
    step(1, 16'h0000, 1, 0, 0, "R1");
    check_armed(1'b1, "R10");
    step(1, 16'hFFF1, 1, 0, 1, "R1");
    step(0, 16'h0000, 0, 0, 0, "R9");

    // R2 edge terms
    do_reset();
    cfg_mode = 3'd0; cfg_term[9 +: 3] = 3'd3; cfg_term[15 +: 3] = 3'd4;
    pulse_arm();
    step(1, 16'h0028, 0, 0, 0, "R2");
    step(1, 16'h0020, 0, 0, 0, "R2");
    step(0, 16'h0000, 0, 0, 0, "R10");
    step(1, 16'h0008, 0, 0, 1, "R2");
    step(0, 16'h0000, 0, 0, 0, "R2");

    // R3 longer than 2
    do_reset();
    cfg_mode = 3'd1; cfg_time = 8'd2; cfg_term[0 +: 3] = 3'd2;
    pulse_arm();
    step(1, 16'h1, 0, 0, 0, "R3");
    step(1, 16'h1, 0, 0, 0, "R3");
    step(1, 16'h0, 0, 0, 0, "R3");
    step(1, 16'h1, 0, 0, 0, "R3");
    step(1, 16'h1, 0, 0, 0, "R3");
    step(1, 16'h1, 0, 0, 1, "R3");
    step(0, 16'h0, 0, 0, 0, "R3");

    // R4 shorter than 2
    do_reset();
    cfg_mode = 3'd2; cfg_time = 8'd2; cfg_term[0 +: 3] = 3'd2;
    pulse_arm();
    step(1, 16'h1, 0, 0, 0, "R4");
    step(1, 16'h1, 0, 0, 0, "R4");
    step(1, 16'h1, 0, 0, 0, "R4");
    step(1, 16'h0, 0, 0, 0, "R4");
    step(1, 16'h1, 0, 0, 0, "R4");
    step(1, 16'h1, 0, 0, 0, "R4");
    step(1, 16'h0, 0, 0, 1, "R4");
    step(0, 16'h0, 0, 0, 0, "R4");

    // R5 start of pattern
    do_reset();
    cfg_mode = 3'd3; cfg_term[0 +: 3] = 3'd2;
    pulse_arm();
    step(1, 16'h1, 0, 0, 1, "R5");
    pulse_arm();
    step(1, 16'h1, 0, 0, 0, "R5");
    step(1, 16'h0, 0, 0, 0, "R5");
    step(1, 16'h1, 0, 0, 1, "R5");
    step(0, 16'h0, 0, 0, 0, "R5");

    // R6 end of pattern
    do_reset();
    cfg_mode = 3'd4; cfg_term[0 +: 3] = 3'd2;
    pulse_arm();
    step(1, 16'h0, 0, 0, 0, "R6");
    step(1, 16'h1, 0, 0, 0, "R6");
    step(1, 16'h1, 0, 0, 0, "R6");
    step(1, 16'h0, 0, 0, 1, "R6");
    step(0, 16'h0, 0, 0, 0, "R6");

    // R7 setup window of 2 samples
    do_reset();
    cfg_mode = 3'd5; cfg_setup = 4'd2;
    pulse_arm();
    step(1, 16'h0, 0, 0, 0, "R7");
    step(1, 16'h0, 0, 1, 0, "R7");
    step(1, 16'h1, 0, 0, 0, "R7");
    step(1, 16'h1, 0, 0, 0, "R7");
    step(1, 16'h1, 0, 1, 0, "R7");
    step(1, 16'h2, 0, 0, 0, "R7");
    step(1, 16'h2, 0, 1, 1, "R7");
    step(0, 16'h2, 0, 0, 0, "R7");

    // R8 hold window of 2 samples
    do_reset();
    cfg_mode = 3'd6; cfg_hold = 4'd2;
    pulse_arm();
    step(1, 16'h0, 0, 1, 0, "R8");
    step(1, 16'h0, 0, 0, 0, "R8");
    step(1, 16'h0, 0, 0, 0, "R8");
    step(1, 16'h1, 0, 0, 0, "R8");
    step(1, 16'h1, 0, 1, 0, "R8");
    step(1, 16'h1, 0, 0, 0, "R8");
    step(1, 16'h4, 0, 0, 1, "R8");
    step(0, 16'h4, 0, 0, 0, "R8");

    @(negedge clk);
    @(negedge clk);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  always @(posedge clk) begin
    cycles++;
    if (cycles > 100000) begin
      errors++;
      checks++;
      $display("FAIL watchdog expired");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule